// File: doc/BRIEF.md
# Flash Page-Program Controller

This block sits between an 8-bit processor bus and a small on-chip flash model. It decides how the processor reaches that flash. Code-space reads are steered onto one of three areas: the main user array, a 128-byte extra row, or a single security byte. Which area is used depends on a 2-bit area selector held in a control register. When the page-load enable bit of that register is set, data-space writes below 4000h do not reach the EEPROM path. They are collected in a 128-byte page buffer instead, with a mask that records which bytes have been loaded.

A program cycle starts only after a two-write unlock. The first control write must carry the key nibble 5h, and the next bus access must be a control write carrying Ah. Idle bus cycles between the two writes are allowed. Once launched, a timed cycle holds the busy flag. At its end, the loaded bytes are copied into the area picked by the selector, and the buffer and its mask are cleared. The flash model is a register array that resets to the erased value FFh. It has a fixed program time, set by a parameter, and no erase step.

The controller is built around a four-state machine:
- ST_IDLE moves to ST_ARMED on a 5h control write.
- ST_ARMED moves to ST_PROG on an Ah control write with selector 00, 01 or 10. It moves back to ST_IDLE on an Ah write with selector 11 or on any other access. A new 5h control write keeps it in ST_ARMED.
- ST_PROG counts down the program time, then moves to ST_COMMIT.
- ST_COMMIT writes the array, clears the buffer and returns to ST_IDLE.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, busy is 0 and a control read returns 00h. Every byte of the user array, the extra row and the security byte reads FFh.
- R2: With page-load enable set, a data write below 4000h stores its byte in the buffer slot given by address bits 6:0. Address bits 14:7, taken modulo the page count, set the target page. Data writes at 4000h or above, or with page-load enable clear, leave the buffer untouched.
- R3: `ee_wr_stb` is 1 during a data write only when `ee_access_en` is 1 and page-load enable is 0. While page-load enable is set, no EEPROM write is decoded.
- R4: For code reads (`acc_kind`=00), the selector picks the mapping. Selector 00 gives the user array at 0000h–3FFFh. Selector 01 gives the extra row at FF80h–FFFFh. Selector 10 gives the security byte at 0000h. Selector 11, and every address outside the mapped window, returns FFh.
- R5: A program cycle starts when a control write with key 5h (data bits 7:4) is followed, as the very next access, by a control write with key Ah. Idle cycles may lie between the two writes.
- R6: Any other access between the 5h and Ah writes cancels the unlock, and the following Ah write then starts nothing. A further 5h control write re-arms the unlock.
- R7: A launch with selector 00 copies the loaded bytes into the target user page. A launch with selector 01 copies them into the extra row, using the same byte offsets.
- R8: A launch with selector 10 ANDs buffer byte 0, if it is loaded, into the security byte, so its bits only go from 1 to 0. A launch with selector 11 does nothing: busy stays 0 and the buffer is kept.
- R9: A control write whose key is not part of a valid 5h-then-Ah pair starts no cycle.
- R10: After a valid launch, busy reads 1 for exactly PROG_CYCLES+1 clock cycles. It is visible on the `busy` port and in bit 0 of a control read. Control data layout: bits 7:4 key (reads 0), bits 3:2 selector, bit 1 page-load enable, bit 0 busy (read-only).
- R11: While busy is 1, control writes and buffer writes are ignored.
- R12: Only loaded bytes change in the array. The buffer and its mask are cleared when the cycle ends, so a later launch with nothing loaded changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Bus access in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_kind | input | 2 | 00 code, 01 data, 10 control register, 11 other |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data |
| ee_access_en | input | 1 | EEPROM-access enable from elsewhere in the chip |
| rd_data | output | 8 | Read data for code and control reads, 00h otherwise |
| busy | output | 1 | Program cycle in progress |
| ee_wr_stb | output | 1 | Decoded EEPROM data write |

## Verification
The bench builds the block with PAGE_SEL_W=2, which gives four user pages. Random page addresses therefore wrap and alias onto pages the bench can read back in full. It also uses PROG_CYCLES=12, so each busy window can be counted to the exact cycle and many launches fit into a short run. With a 512-byte user array, the whole array and the whole extra row can be compared against the bench model after the random phase.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [1:0] {
        ACC_CODE  = 2'b00,
        ACC_DATA  = 2'b01,
        ACC_CTRL  = 2'b10,
        ACC_OTHER = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        SP_USER   = 2'b00,
        SP_XROW   = 2'b01,
        SP_SECURE = 2'b10,
        SP_RSVD   = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PROG,
        ST_COMMIT
    } prog_state_e;

    localparam logic [3:0] KEY_FIRST  = 4'h5;
    localparam logic [3:0] KEY_SECOND = 4'hA;

    typedef struct packed {
        logic [3:0] key;
        space_e     space;
        logic       load_en;
        logic       busy_ro;
    } ctrl_word_t;

endpackage

// File: rtl/fpc_key_fsm.sv
module fpc_key_fsm
    import flash_prog_pkg::*;
#(
    parameter int PROG_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en,
    input  logic       ctrl_wr,
    input  logic [3:0] key,
    input  space_e     key_space,
    output logic       busy,
    output logic       commit,
    output space_e     commit_space
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

    prog_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    space_e           space_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr && key == KEY_FIRST) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (acc_en) begin
                    if (ctrl_wr && key == KEY_SECOND)
                        state_d = (key_space == SP_RSVD) ? ST_IDLE : ST_PROG;
                    else if (ctrl_wr && key == KEY_FIRST)
                        state_d = ST_ARMED;
                    else
                        state_d = ST_IDLE;
                end
            end
            ST_PROG: begin
                if (cnt_q == '0) state_d = ST_COMMIT;
            end
            ST_COMMIT: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // program timer and captured target area
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            space_q <= SP_USER;
        end else if (state_q == ST_ARMED && state_d == ST_PROG) begin
            cnt_q   <= CNT_LOAD;
            space_q <= key_space;
        end else if (state_q == ST_PROG && cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy   = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ARMED: ;
            ST_PROG:   busy = 1'b1;
            ST_COMMIT: begin
                busy   = 1'b1;
                commit = 1'b1;
            end
        endcase
    end
    assign commit_space = space_q;

    assert_launch_after_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) != ST_PROG) |-> $past(state_q) == ST_ARMED);

    assert_abort_on_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && acc_en && !(ctrl_wr && key == KEY_SECOND))
        |=> state_q != ST_PROG);

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && cnt_q != '0) |=> busy);

    assert_commit_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/fpc_page_buf.sv
module fpc_page_buf #(
    parameter int OFF_W      = 7,
    parameter int PAGE_SEL_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [OFF_W-1:0]                 wr_off,
    input  logic [PAGE_SEL_W-1:0]            wr_page,
    input  logic [7:0]                       wr_data,
    input  logic                             clr,
    input  logic                             busy,
    output logic [(1<<OFF_W)-1:0][7:0]       buf_data,
    output logic [(1<<OFF_W)-1:0]            buf_mask,
    output logic [PAGE_SEL_W-1:0]            buf_page
);
    localparam int PAGE_BYTES = 1 << OFF_W;

    logic [PAGE_BYTES-1:0][7:0] data_q;
    logic [PAGE_BYTES-1:0]      mask_q;
    logic [PAGE_SEL_W-1:0]      page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '{default: 8'hFF};
            mask_q <= '0;
            page_q <= '0;
        end else if (clr) begin
            data_q <= '{default: 8'hFF};
            mask_q <= '0;
        end else if (wr_en) begin
            data_q[wr_off] <= wr_data;
            mask_q[wr_off] <= 1'b1;
            page_q         <= wr_page;
        end
    end

    assign buf_data = data_q;
    assign buf_mask = mask_q;
    assign buf_page = page_q;

    assert_clear_after_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> mask_q == '0);

    assert_no_load_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clr) |=> $stable(mask_q) && $stable(data_q));

endmodule

// File: rtl/fpc_flash_array.sv
module fpc_flash_array
    import flash_prog_pkg::*;
#(
    parameter int OFF_W      = 7,
    parameter int PAGE_SEL_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             commit,
    input  space_e                           commit_space,
    input  logic [(1<<OFF_W)-1:0][7:0]       buf_data,
    input  logic [(1<<OFF_W)-1:0]            buf_mask,
    input  logic [PAGE_SEL_W-1:0]            buf_page,
    input  space_e                           rd_space,
    input  logic [15:0]                      rd_addr,
    output logic [7:0]                       rd_byte
);
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int USER_AW    = OFF_W + PAGE_SEL_W;
    localparam int USER_BYTES = 1 << USER_AW;

    logic [7:0] user_q [USER_BYTES];
    logic [7:0] xrow_q [PAGE_BYTES];
    logic [7:0] sec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < USER_BYTES; j++) user_q[j] <= 8'hFF;
        end else if (commit && commit_space == SP_USER) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (buf_mask[i]) user_q[{buf_page, i[OFF_W-1:0]}] <= buf_data[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < PAGE_BYTES; j++) xrow_q[j] <= 8'hFF;
        end else if (commit && commit_space == SP_XROW) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (buf_mask[i]) xrow_q[i] <= buf_data[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sec_q <= 8'hFF;
        else if (commit && commit_space == SP_SECURE && buf_mask[0])
            sec_q <= sec_q & buf_data[0];
    end

    // code-space read mapping
    always_comb begin
        rd_byte = 8'hFF;
        unique case (rd_space)
            SP_USER:   if (rd_addr[15:14] == 2'b00) rd_byte = user_q[rd_addr[USER_AW-1:0]];
            SP_XROW:   if (&rd_addr[15:OFF_W])      rd_byte = xrow_q[rd_addr[OFF_W-1:0]];
            SP_SECURE: if (rd_addr == 16'h0000)     rd_byte = sec_q;
            SP_RSVD:   rd_byte = 8'hFF;
        endcase
    end

    assert_secure_only_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sec_q & ~$past(sec_q)) == 8'h00);

    assert_secure_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(sec_q));

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int OFF_W       = 7,
    parameter int PAGE_SEL_W  = 3,
    parameter int PROG_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic [1:0]  acc_kind,
    input  logic [15:0] acc_addr,
    input  logic [7:0]  acc_wdata,
    input  logic        ee_access_en,
    output logic [7:0]  rd_data,
    output logic        busy,
    output logic        ee_wr_stb
);
    localparam int PAGE_BYTES = 1 << OFF_W;

    acc_kind_e  kind;
    ctrl_word_t wr_word;
    ctrl_word_t rd_word;
    logic       load_en_q;
    space_e     space_q;
    logic       ctrl_wr_any, ctrl_wr_ok, data_wr, buf_wr;
    logic       commit;
    space_e     commit_space;
    logic [PAGE_BYTES-1:0][7:0] buf_data;
    logic [PAGE_BYTES-1:0]      buf_mask;
    logic [PAGE_SEL_W-1:0]      buf_page;
    logic [7:0] arr_byte;

    assign kind    = acc_kind_e'(acc_kind);
    assign wr_word = ctrl_word_t'(acc_wdata);

    assign ctrl_wr_any = acc_en && acc_wr && kind == ACC_CTRL;
    assign ctrl_wr_ok  = ctrl_wr_any && !busy;
    assign data_wr     = acc_en && acc_wr && kind == ACC_DATA;
    assign buf_wr      = data_wr && load_en_q && acc_addr[15:14] == 2'b00 && !busy;
    assign ee_wr_stb   = data_wr && ee_access_en && !load_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_en_q <= 1'b0;
            space_q   <= SP_USER;
        end else if (ctrl_wr_ok) begin
            load_en_q <= wr_word.load_en;
            space_q   <= wr_word.space;
        end
    end

    fpc_key_fsm #(.PROG_CYCLES(PROG_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_en       (acc_en),
        .ctrl_wr      (ctrl_wr_any),
        .key          (wr_word.key),
        .key_space    (wr_word.space),
        .busy         (busy),
        .commit       (commit),
        .commit_space (commit_space)
    );

    fpc_page_buf #(.OFF_W(OFF_W), .PAGE_SEL_W(PAGE_SEL_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_wr),
        .wr_off   (acc_addr[OFF_W-1:0]),
        .wr_page  (acc_addr[OFF_W +: PAGE_SEL_W]),
        .wr_data  (acc_wdata),
        .clr      (commit),
        .busy     (busy),
        .buf_data (buf_data),
        .buf_mask (buf_mask),
        .buf_page (buf_page)
    );

    fpc_flash_array #(.OFF_W(OFF_W), .PAGE_SEL_W(PAGE_SEL_W)) u_arr (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit),
        .commit_space (commit_space),
        .buf_data     (buf_data),
        .buf_mask     (buf_mask),
        .buf_page     (buf_page),
        .rd_space     (space_q),
        .rd_addr      (acc_addr),
        .rd_byte      (arr_byte)
    );

    always_comb begin
        rd_word         = '0;
        rd_word.space   = space_q;
        rd_word.load_en = load_en_q;
        rd_word.busy_ro = busy;
        rd_data = 8'h00;
        if (acc_en && !acc_wr) begin
            if (kind == ACC_CODE)      rd_data = arr_byte;
            else if (kind == ACC_CTRL) rd_data = rd_word;
        end
    end

    assert_ee_excludes_buffer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ee_wr_stb && buf_wr));

    assert_ctrl_frozen_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(load_en_q) && $stable(space_q));

endmodule

// File: tb/flash_prog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_prog_ctrl_tb;
    localparam int PSW   = 2;
    localparam int PCYC  = 12;
    localparam int UBYTES = 128 << PSW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_en = 0, acc_wr = 0, ee_access_en = 0;
    logic [1:0] acc_kind = 0;
    logic [15:0] acc_addr = 0;
    logic [7:0] acc_wdata = 0;
    logic [7:0] rd_data;
    logic busy, ee_wr_stb;

    int n_checks = 0, n_errors = 0;
    logic [7:0] user_m [UBYTES];
    logic [7:0] xrow_m [128];
    logic [7:0] sec_m;
    logic [7:0] buf_m [128];
    logic       mask_m [128];
    int         page_m;
    logic       load_m;
    logic [1:0] space_m;

    always #2.5 clk = ~clk;

    flash_prog_ctrl #(.OFF_W(7), .PAGE_SEL_W(PSW), .PROG_CYCLES(PCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .ee_access_en(ee_access_en), .rd_data(rd_data), .busy(busy),
        .ee_wr_stb(ee_wr_stb));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input logic [15:0] a);
        case (space_m)
            2'b00: return (a < 16'h4000) ? user_m[a[PSW+6:0]] : 8'hFF;
            2'b01: return (a >= 16'hFF80) ? xrow_m[a[6:0]] : 8'hFF;
            2'b10: return (a == 16'h0000) ? sec_m : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic do_acc(input logic [1:0] k, input logic w, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1; acc_kind = k; acc_wr = w; acc_addr = a; acc_wdata = d;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); acc_en = 0; end
    endtask

    task automatic ctrl_wr(input logic [3:0] key, input logic [1:0] sp, input logic le);
        do_acc(2'b10, 1, 16'h0, {key, sp, le, 1'b0});
        load_m = le; space_m = sp;
    endtask

    task automatic buf_wr(input logic [15:0] a, input logic [7:0] d);
        do_acc(2'b01, 1, a, d);
        if (load_m && a < 16'h4000) begin
            buf_m[a[6:0]] = d; mask_m[a[6:0]] = 1'b1; page_m = int'(a[14:7]) % (1 << PSW);
        end
    endtask

    task automatic code_chk(input string req, input logic [15:0] a);
        @(negedge clk);
        acc_en = 1; acc_kind = 2'b00; acc_wr = 0; acc_addr = a;
        #1 chk(req, {8'h0, rd_data}, {8'h0, exp_code(a)});
        @(posedge clk);
    endtask

    task automatic ctrl_chk(input string req, input logic [7:0] exp);
        @(negedge clk);
        acc_en = 1; acc_kind = 2'b10; acc_wr = 0;
        #1 chk(req, {8'h0, rd_data}, {8'h0, exp});
        @(posedge clk);
    endtask

    task automatic apply_model(input logic [1:0] sp);
        for (int i = 0; i < 128; i++) if (mask_m[i]) begin
            if (sp == 2'b00) user_m[page_m*128 + i] = buf_m[i];
            if (sp == 2'b01) xrow_m[i] = buf_m[i];
        end
        if (sp == 2'b10 && mask_m[0]) sec_m = sec_m & buf_m[0];
        for (int i = 0; i < 128; i++) begin mask_m[i] = 0; buf_m[i] = 8'hFF; end
    endtask

    // count cycles with busy high after the last access; bus left idle
    task automatic busy_len(output int n);
        n = 0;
        for (int c = 0; c < 1000; c++) begin
            @(negedge clk); acc_en = 0;
            #1 if (!busy) break;
            n++;
        end
    endtask

    task automatic launch(input logic [1:0] sp, input string req);
        int n;
        ctrl_wr(4'h5, sp, load_m);
        ctrl_wr(4'hA, sp, load_m);
        busy_len(n);
        chk(req, 16'(n), (sp == 2'b11) ? 16'd0 : 16'(PCYC + 1));
        if (sp != 2'b11) apply_model(sp);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        logic [15:0] a;
        logic [1:0] sp;
        void'($urandom(32'd4242));
        for (int i = 0; i < UBYTES; i++) user_m[i] = 8'hFF;
        for (int i = 0; i < 128; i++) begin xrow_m[i] = 8'hFF; buf_m[i] = 8'hFF; mask_m[i] = 0; end
        sec_m = 8'hFF; page_m = 0; load_m = 0; space_m = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        #1 chk("R1 busy", {15'h0, busy}, 16'h0);
        ctrl_chk("R1 ctrl", 8'h00);
        code_chk("R1 user", 16'h0000);
        ctrl_wr(4'h0, 2'b10, 0); code_chk("R1 secure", 16'h0000);
        ctrl_wr(4'h0, 2'b01, 0); code_chk("R1 xrow", 16'hFFC3);

        // R3 EEPROM decode priority
        ee_access_en = 1;
        @(negedge clk); acc_en = 1; acc_kind = 2'b01; acc_wr = 1; acc_addr = 16'h0010; acc_wdata = 8'h33;
        #1 chk("R3 ee when load off", {15'h0, ee_wr_stb}, 16'h1);
        @(posedge clk);
        ctrl_wr(4'h0, 2'b00, 1);
        @(negedge clk); acc_en = 1; acc_kind = 2'b01; acc_wr = 1; acc_addr = 16'h0010; acc_wdata = 8'h33;
        #1 chk("R3 ee blocked by load", {15'h0, ee_wr_stb}, 16'h0);
        @(posedge clk);
        buf_m[16] = 8'h33; mask_m[16] = 1; page_m = 0;
        ee_access_en = 0;

        // R9 stray keys; R6 aborts
        ctrl_wr(4'hA, 2'b00, 1); busy_len(n); chk("R9 lone A", 16'(n), 16'd0);
        ctrl_wr(4'h7, 2'b00, 1); ctrl_wr(4'hA, 2'b00, 1); busy_len(n); chk("R9 7 then A", 16'(n), 16'd0);
        ctrl_wr(4'h5, 2'b00, 1); code_chk("R6 read between", 16'h0010);
        ctrl_wr(4'hA, 2'b00, 1); busy_len(n); chk("R6 abort by read", 16'(n), 16'd0);
        ctrl_wr(4'h5, 2'b00, 1); do_acc(2'b11, 1, 16'h1234, 8'h00);
        ctrl_wr(4'hA, 2'b00, 1); busy_len(n); chk("R6 abort by other", 16'(n), 16'd0);
        code_chk("R6 user untouched", 16'h0010);
        ctrl_wr(4'h5, 2'b00, 1); ctrl_wr(4'h5, 2'b00, 1); ctrl_wr(4'hA, 2'b00, 1);
        busy_len(n); chk("R6 rearm", 16'(n), 16'(PCYC + 1));
        apply_model(2'b00);
        code_chk("R7 user byte", 16'h0010);

        // R5 idle cycles between keys allowed; R2 page wrap and out-of-range
        buf_wr(16'h0285, 8'hC1);
        buf_wr(16'h4005, 8'h99);
        ctrl_wr(4'h5, 2'b00, 1); idle(3); ctrl_wr(4'hA, 2'b00, 1);
        busy_len(n); chk("R5 idle gap", 16'(n), 16'(PCYC + 1));
        apply_model(2'b00);
        code_chk("R2 wrapped page", 16'h0085);
        code_chk("R2 unloaded neighbour", 16'h0005);

        // R8 security byte only clears bits; selector 11 does nothing
        buf_wr(16'h0000, 8'h5A); launch(2'b10, "R8 secure len");
        code_chk("R8 secure 5A", 16'h0000);
        buf_wr(16'h0000, 8'hA5); launch(2'b10, "R8 secure len2");
        code_chk("R8 secure 00", 16'h0000);
        buf_wr(16'h0000, 8'hFF); launch(2'b10, "R8 secure len3");
        code_chk("R8 secure no set", 16'h0000);
        code_chk("R4 secure other addr", 16'h0001);
        buf_wr(16'h0003, 8'h12); launch(2'b11, "R8 reserved no busy");
        code_chk("R4 reserved FF", 16'h0003);
        launch(2'b01, "R7 xrow len");
        code_chk("R7 xrow kept buffer", 16'hFF83);
        code_chk("R4 xrow below window", 16'hFF7F);

        // R10 and R11 busy visibility and ignored writes
        ctrl_wr(4'h0, 2'b00, 1);
        buf_wr(16'h0101, 8'h77);
        ctrl_wr(4'h5, 2'b00, 1); ctrl_wr(4'hA, 2'b00, 1);
        do_acc(2'b10, 1, 16'h0, {4'h0, 2'b01, 1'b0, 1'b0});
        ctrl_chk("R10 busy bit", 8'h03);
        do_acc(2'b01, 1, 16'h0102, 8'h66);
        busy_len(n);
        ctrl_chk("R11 ctrl ignored", 8'h02);
        apply_model(2'b00);
        code_chk("R11 programmed", 16'h0101);
        code_chk("R11 busy write dropped", 16'h0102);
        // R12 empty launch changes nothing
        launch(2'b00, "R12 empty len");
        code_chk("R12 unchanged", 16'h0101);

        // random phase
        for (int it = 0; it < 40; it++) begin
            ctrl_wr(4'h0, 2'($urandom_range(0, 3)), 1);
            for (int w = 0; w < int'($urandom_range(1, 6)); w++) begin
                a = 16'($urandom_range(0, 16'h3FFF));
                if ($urandom_range(0, 9) == 0) a = a | 16'h4000;
                buf_wr(a, 8'($urandom));
            end
            sp = ($urandom_range(0, 7) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
            launch(sp, "R7 random launch");
            ctrl_wr(4'h0, sp, 1);
            for (int r = 0; r < 6; r++) begin
                a = (sp == 2'b01) ? 16'hFF80 | 16'($urandom_range(0, 127))
                  : (sp == 2'b10) ? 16'($urandom_range(0, 1))
                  : 16'($urandom_range(0, 16'h41FF));
                code_chk("R4 random read", a);
            end
        end

        // full comparison
        ctrl_wr(4'h0, 2'b00, 0);
        for (int i = 0; i < UBYTES; i++) code_chk("R12 user sweep", 16'(i));
        ctrl_wr(4'h0, 2'b01, 0);
        for (int i = 0; i < 128; i++) code_chk("R12 xrow sweep", 16'hFF80 + 16'(i));
        ctrl_wr(4'h0, 2'b10, 0);
        code_chk("R8 final secure", 16'h0000);
        idle(2);
        finish_run();
    end
endmodule